// File: doc/BRIEF.md
# Windowed Memory Address Translator

This block turns a processor's 16-bit data addresses and word-granular fetch addresses into physical targets. A target is one of three memories: internal data RAM, instruction RAM, or a numbered region of a large unified memory. Three 16-bit mapping registers steer the translation. One data map controls a 16 KB window in the data space. Two fetch maps each control one 128 KB half of the fetch space. In every map, bit 12 set points the access at instruction RAM, and with bit 12 clear the low bits name a unified region. If an access lands in an unpopulated unified region, or in an illegal part of the data I/O space, a bus-error flag is raised.

The data port and the fetch port are independent. A request presented in one cycle produces a registered result (target, region, physical offset, bus error) with a valid strobe in the next cycle. The results hold until the next request on that port. A register write port updates the maps. A write changes the translation of requests from the following cycle on.

Top module: `mem_window_xlate`

## Requirements
- R1: When reset is released, the data map holds 0x0000 and both fetch maps hold 0x1000. As a result, fetches target instruction RAM, and data window accesses target unified region 0 at base 0.
- R2: A data address from 0x0000 to 0x7FFF gives target code 0 (data RAM), offset equal to the address, region 0, and no bus error.
- R3: A data address from 0xC000 to 0xFFFF gives target code 0 with offset equal to the address. The bus error is set unless bits [15:4] of the address equal 0xFF0.
- R4: A data address from 0x8000 to 0xBFFF, with data-map bit 12 set, gives target code 1 (instruction RAM). The offset is data-map bits [3:0] times 0x4000 plus address bits [13:0], and no bus error is raised.
- R5: A data address from 0x8000 to 0xBFFF, with data-map bit 12 clear, gives target code 2 (unified). The region is data-map bits [9:3]. The offset is data-map bits [2:0] times 0x4000 plus address bits [13:0].
- R6: The fetch byte address is the fetch word address shifted left by two. If byte-address bit 17 is set, fetch map 1 is used; otherwise fetch map 0 is used.
- R7: If the selected fetch map has bit 12 set, the fetch gives target code 1 with offset equal to the 18-bit byte address. Otherwise it gives target code 2, region equal to map bits [7:0], and offset equal to byte-address bits [16:0].
- R8: A unified-region target raises the bus error exactly when the region is not one of 0, 1, 2 or 127. Data RAM and instruction RAM targets in the windows never raise it.
- R9: A request on either port is answered with a one-cycle valid pulse one clock later. A map write affects only requests presented after the write's clock edge.
- R10: The map select code picks the map a write goes to: 0 is the data map, 1 is fetch map 0, 2 is fetch map 1. A write with select code 3 changes no map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_we | input | 1 | Map register write strobe |
| map_sel | input | 2 | Map select: 0 data, 1 fetch map 0, 2 fetch map 1, 3 none |
| map_wdata | input | 16 | Value written to the selected map |
| d_req | input | 1 | Data translation request |
| d_addr | input | 16 | Data byte address |
| f_req | input | 1 | Fetch translation request |
| f_pc | input | 16 | Fetch word address |
| d_vld | output | 1 | Data result valid |
| d_tgt | output | 2 | Data target: 0 data RAM, 1 instruction RAM, 2 unified |
| d_region | output | 8 | Data unified region number |
| d_off | output | 18 | Data physical offset |
| d_berr | output | 1 | Data bus error |
| f_vld | output | 1 | Fetch result valid |
| f_tgt | output | 2 | Fetch target, same coding as d_tgt |
| f_region | output | 8 | Fetch unified region number |
| f_off | output | 18 | Fetch physical offset |
| f_berr | output | 1 | Fetch bus error |

## Verification
Some properties are checked on every cycle. The valid strobe must follow each request by exactly one cycle. Low data RAM and instruction-RAM results must never carry a bus error. Fetch offsets into instruction RAM must be word aligned. A write with the unused select code must leave every map unchanged. I/O results outside the legal 16-byte page must flag an error. The exact offset and region arithmetic of the window and the fetch halves can only be shown by the bench's scenarios. The same holds for the reset map contents seen through translations, the choice between the two fetch maps, and the fact that a write in the same cycle as a request does not yet apply to it.

// File: rtl/xlate_pkg.sv
// Shared types and helpers for the windowed address translator.
// Assumes a fixed set of populated unified regions.
package xlate_pkg;
    typedef enum logic [1:0] {
        TGT_DRAM = 2'd0,
        TGT_IRAM = 2'd1,
        TGT_UNI  = 2'd2
    } tgt_e;

    localparam int MAP_IDX_DATA = 0;
    localparam int MAP_IDX_F0   = 1;
    localparam int MAP_IDX_F1   = 2;

    // Populated unified regions
    function automatic logic region_present(input logic [7:0] r);
        return (r == 8'd0) || (r == 8'd1) || (r == 8'd2) || (r == 8'd127);
    endfunction

    // Reset value of each map register
    function automatic logic [15:0] map_reset_val(input int idx);
        return (idx == MAP_IDX_DATA) ? 16'h0000 : 16'h1000;
    endfunction
endpackage

// File: rtl/xlate_map_regs.sv
// Map register file: one data map and two fetch maps, written through one port.
// Assumes select codes at or beyond NUM_MAPS address no register.
module xlate_map_regs #(
    parameter int MAP_W    = 16,
    parameter int NUM_MAPS = 3,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [MAP_W-1:0] wdata,
    output logic [MAP_W-1:0] dmap,
    output logic [MAP_W-1:0] imap0,
    output logic [MAP_W-1:0] imap1
);
    import xlate_pkg::*;

    logic [NUM_MAPS-1:0][MAP_W-1:0] map_q;

    for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
        // Hold or load one map register
        always_ff @(posedge clk) begin
            if (!rst_n)
                map_q[g] <= MAP_W'(map_reset_val(g));
            else if (we && (sel == SEL_W'(g)))
                map_q[g] <= wdata;
        end
    end

    assign dmap  = map_q[MAP_IDX_DATA];
    assign imap0 = map_q[MAP_IDX_F0];
    assign imap1 = map_q[MAP_IDX_F1];

    // R10
    unused_sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (sel >= SEL_W'(NUM_MAPS))) |=> $stable(map_q));

    // R1
    reset_maps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (map_q[MAP_IDX_DATA] == 16'h0000) &&
                         (map_q[MAP_IDX_F0] == 16'h1000) &&
                         (map_q[MAP_IDX_F1] == 16'h1000));
endmodule

// File: rtl/xlate_data_path.sv
// Combinational data-address translation: low RAM, mapped window, I/O space.
// Assumes map bit 12 selects instruction RAM and bits [9:3]/[2:0] pick region/base.
module xlate_data_path #(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 14,
    parameter int OFF_W  = 18,
    parameter int REG_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dmap,
    output logic [1:0]        tgt,
    output logic [REG_W-1:0]  region,
    output logic [OFF_W-1:0]  off,
    output logic              berr
);
    import xlate_pkg::*;

    localparam int          IO_TAG_W = ADDR_W - 4;
    localparam logic [IO_TAG_W-1:0] IO_TAG = IO_TAG_W'(12'hFF0);

    logic [WIN_W-1:0] low_bits;
    logic             unused_map_bits;

    assign low_bits        = addr[WIN_W-1:0];
    assign unused_map_bits = ^{dmap[15:13], dmap[11:10]};

    // Decode the address quadrant and form target, region, offset, error
    always_comb begin
        tgt    = TGT_DRAM;
        region = '0;
        off    = OFF_W'(addr);
        berr   = 1'b0;
        case (addr[ADDR_W-1:ADDR_W-2])
            2'b11: berr = (addr[ADDR_W-1:4] != IO_TAG);
            2'b10: begin
                if (dmap[12]) begin
                    tgt = TGT_IRAM;
                    off = (OFF_W'(dmap[3:0]) << WIN_W) + OFF_W'(low_bits);
                end else begin
                    tgt    = TGT_UNI;
                    region = REG_W'(dmap[9:3]);
                    off    = (OFF_W'(dmap[2:0]) << WIN_W) + OFF_W'(low_bits);
                    berr   = !region_present(8'(dmap[9:3]));
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xlate_fetch_path.sv
// Combinational fetch translation: word address to byte address, map pick, target.
// Assumes byte-address bit 17 picks the upper fetch map.
module xlate_fetch_path #(
    parameter int PC_W  = 16,
    parameter int OFF_W = 18,
    parameter int REG_W = 8
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [15:0]      imap0,
    input  logic [15:0]      imap1,
    output logic [1:0]       tgt,
    output logic [REG_W-1:0] region,
    output logic [OFF_W-1:0] off,
    output logic             berr
);
    import xlate_pkg::*;

    localparam int BYTE_W = PC_W + 2;

    logic [BYTE_W-1:0] byte_a;
    logic [15:0]       map_sel;
    logic              unused_map_bits;

    assign byte_a          = {pc, 2'b00};
    assign map_sel         = byte_a[BYTE_W-1] ? imap1 : imap0;
    assign unused_map_bits = ^{map_sel[15:13], map_sel[11:8]};

    // Pick instruction RAM or a unified region from the selected map
    always_comb begin
        if (map_sel[12]) begin
            tgt    = TGT_IRAM;
            region = '0;
            off    = OFF_W'(byte_a);
            berr   = 1'b0;
        end else begin
            tgt    = TGT_UNI;
            region = REG_W'(map_sel[7:0]);
            off    = OFF_W'(byte_a[BYTE_W-2:0]);
            berr   = !region_present(map_sel[7:0]);
        end
    end
endmodule

// File: rtl/mem_window_xlate.sv
// Top: map registers plus data and fetch translators with registered results.
// Assumes requests are single-cycle strobes; results hold until the next request.
module mem_window_xlate #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 18,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_we,
    input  logic [1:0]        map_sel,
    input  logic [15:0]       map_wdata,
    input  logic              d_req,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic              f_req,
    input  logic [ADDR_W-1:0] f_pc,
    output logic              d_vld,
    output logic [1:0]        d_tgt,
    output logic [REG_W-1:0]  d_region,
    output logic [OFF_W-1:0]  d_off,
    output logic              d_berr,
    output logic              f_vld,
    output logic [1:0]        f_tgt,
    output logic [REG_W-1:0]  f_region,
    output logic [OFF_W-1:0]  f_off,
    output logic              f_berr
);
    import xlate_pkg::*;

    logic [15:0]      dmap, imap0, imap1;
    logic [1:0]       dc_tgt, fc_tgt;
    logic [REG_W-1:0] dc_region, fc_region;
    logic [OFF_W-1:0] dc_off, fc_off;
    logic             dc_berr, fc_berr;

    xlate_map_regs #(.MAP_W(16), .NUM_MAPS(3), .SEL_W(2)) maps_i (
        .clk(clk), .rst_n(rst_n), .we(map_we), .sel(map_sel), .wdata(map_wdata),
        .dmap(dmap), .imap0(imap0), .imap1(imap1)
    );

    xlate_data_path #(.ADDR_W(ADDR_W), .WIN_W(14), .OFF_W(OFF_W), .REG_W(REG_W)) dpath_i (
        .addr(d_addr), .dmap(dmap),
        .tgt(dc_tgt), .region(dc_region), .off(dc_off), .berr(dc_berr)
    );

    xlate_fetch_path #(.PC_W(ADDR_W), .OFF_W(OFF_W), .REG_W(REG_W)) fpath_i (
        .pc(f_pc), .imap0(imap0), .imap1(imap1),
        .tgt(fc_tgt), .region(fc_region), .off(fc_off), .berr(fc_berr)
    );

    // Register data-port results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_vld <= 1'b0; d_tgt <= '0; d_region <= '0; d_off <= '0; d_berr <= 1'b0;
        end else begin
            d_vld <= d_req;
            if (d_req) begin
                d_tgt <= dc_tgt; d_region <= dc_region; d_off <= dc_off; d_berr <= dc_berr;
            end
        end
    end

    // Register fetch-port results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_vld <= 1'b0; f_tgt <= '0; f_region <= '0; f_off <= '0; f_berr <= 1'b0;
        end else begin
            f_vld <= f_req;
            if (f_req) begin
                f_tgt <= fc_tgt; f_region <= fc_region; f_off <= fc_off; f_berr <= fc_berr;
            end
        end
    end

    // R9
    d_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_req |=> d_vld);
    // R9
    f_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_req |=> f_vld);
    // R2
    d_low_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_vld && d_tgt == TGT_DRAM && !d_off[15]) |-> !d_berr);
    // R3
    d_io_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d_vld && d_tgt == TGT_DRAM && d_off[15:14] == 2'b11 && d_off[15:4] != 12'hFF0) |-> d_berr);
    // R8
    iram_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((d_vld && d_tgt == TGT_IRAM) || (f_vld && f_tgt == TGT_IRAM)) |-> !(d_vld && d_tgt == TGT_IRAM && d_berr) && !(f_vld && f_tgt == TGT_IRAM && f_berr));
    // R6
    f_word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_vld && f_tgt == TGT_IRAM) |-> (f_off[1:0] == 2'b00));
endmodule

// File: tb/mem_window_xlate_tb_top.sv
`timescale 1ns/1ps
module mem_window_xlate_tb_top;
    typedef struct packed {
        logic [1:0]  tgt;
        logic [7:0]  region;
        logic [17:0] off;
        logic        berr;
    } res_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_we = 1'b0;
    logic [1:0]  map_sel = '0;
    logic [15:0] map_wdata = '0;
    logic        d_req = 1'b0;
    logic [15:0] d_addr = '0;
    logic        f_req = 1'b0;
    logic [15:0] f_pc = '0;
    logic        d_vld, d_berr, f_vld, f_berr;
    logic [1:0]  d_tgt, f_tgt;
    logic [7:0]  d_region, f_region;
    logic [17:0] d_off, f_off;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    res_t  dq[$];
    string dtag[$];
    res_t  fq[$];
    string ftag[$];

    logic [15:0] m_dmap = 16'h0000, m_im0 = 16'h1000, m_im1 = 16'h1000;

    always #2.5 clk = ~clk;

    mem_window_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_sel(map_sel), .map_wdata(map_wdata),
        .d_req(d_req), .d_addr(d_addr), .f_req(f_req), .f_pc(f_pc),
        .d_vld(d_vld), .d_tgt(d_tgt), .d_region(d_region), .d_off(d_off), .d_berr(d_berr),
        .f_vld(f_vld), .f_tgt(f_tgt), .f_region(f_region), .f_off(f_off), .f_berr(f_berr)
    );

    function automatic bit pop_ok(input logic [7:0] r);
        return (r == 0) || (r == 1) || (r == 2) || (r == 127);
    endfunction

    function automatic res_t model_data(input logic [15:0] a);
        res_t r;
        r = '{tgt: 2'd0, region: 8'd0, off: {2'b00, a}, berr: 1'b0};
        if (a >= 16'hC000) r.berr = (a[15:4] != 12'hFF0);
        else if (a >= 16'h8000) begin
            if (m_dmap[12]) begin
                r.tgt = 2'd1;
                r.off = 18'(m_dmap[3:0]) * 18'h4000 + 18'(a[13:0]);
            end else begin
                r.tgt = 2'd2;
                r.region = {1'b0, m_dmap[9:3]};
                r.off = 18'(m_dmap[2:0]) * 18'h4000 + 18'(a[13:0]);
                r.berr = !pop_ok(r.region);
            end
        end
        return r;
    endfunction

    function automatic res_t model_fetch(input logic [15:0] pc);
        res_t r;
        logic [17:0] b;
        logic [15:0] m;
        b = {pc, 2'b00};
        m = b[17] ? m_im1 : m_im0;
        if (m[12]) r = '{tgt: 2'd1, region: 8'd0, off: b, berr: 1'b0};
        else begin
            r = '{tgt: 2'd2, region: m[7:0], off: {1'b0, b[16:0]}, berr: 1'b0};
            r.berr = !pop_ok(m[7:0]);
        end
        return r;
    endfunction

    task automatic model_write(input logic [1:0] s, input logic [15:0] v);
        if (s == 2'd0) m_dmap = v;
        else if (s == 2'd1) m_im0 = v;
        else if (s == 2'd2) m_im1 = v;
    endtask

    // Driver: one data request, expectation pushed
    task automatic drive_data(input logic [15:0] a, input string tag);
        d_req = 1'b1; d_addr = a;
        dq.push_back(model_data(a)); dtag.push_back(tag);
        @(negedge clk);
        d_req = 1'b0;
    endtask

    task automatic drive_fetch(input logic [15:0] pc, input string tag);
        f_req = 1'b1; f_pc = pc;
        fq.push_back(model_fetch(pc)); ftag.push_back(tag);
        @(negedge clk);
        f_req = 1'b0;
    endtask

    task automatic write_map(input logic [1:0] s, input logic [15:0] v);
        map_we = 1'b1; map_sel = s; map_wdata = v;
        @(negedge clk);
        map_we = 1'b0;
        model_write(s, v);
    endtask

    // Request and write in the same cycle: request sees the old map
    task automatic data_with_write(input logic [15:0] a, input logic [1:0] s,
                                   input logic [15:0] v, input string tag);
        d_req = 1'b1; d_addr = a;
        map_we = 1'b1; map_sel = s; map_wdata = v;
        dq.push_back(model_data(a)); dtag.push_back(tag);
        @(negedge clk);
        d_req = 1'b0; map_we = 1'b0;
        model_write(s, v);
    endtask

    task automatic cmp(input string port, input string tag, input res_t act, input res_t exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual tgt=%0d reg=%0d off=%h err=%0b expected tgt=%0d reg=%0d off=%h err=%0b",
                     tag, port, act.tgt, act.region, act.off, act.berr,
                     exp.tgt, exp.region, exp.off, exp.berr);
        end
    endtask

    // Monitor: pop and compare results as they appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (d_vld) begin
                if (dq.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R9 data: actual unexpected valid expected none");
                end else cmp("data", dtag.pop_front(), '{d_tgt, d_region, d_off, d_berr}, dq.pop_front());
            end
            if (f_vld) begin
                if (fq.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R9 fetch: actual unexpected valid expected none");
                end else cmp("fetch", ftag.pop_front(), '{f_tgt, f_region, f_off, f_berr}, fq.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: no valid strobe during reset
        n_checks++;
        if (d_vld !== 1'b0 || f_vld !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 reset: actual vld=%b%b expected 00", d_vld, f_vld);
        end
        rst_n = 1'b1;
        @(negedge clk);

        drive_fetch(16'h0000, "R1");
        drive_fetch(16'h8000, "R1 R6");
        drive_data(16'h8123, "R1");
        drive_data(16'h0000, "R2");
        drive_data(16'h7FFF, "R2");
        drive_data(16'hFF00, "R3");
        drive_data(16'hFF0F, "R3");
        drive_data(16'hFF10, "R3");
        drive_data(16'hC000, "R3");
        drive_data(16'hFFFF, "R3");

        write_map(2'd0, 16'h1005);
        drive_data(16'h8000, "R4");
        drive_data(16'hBFFF, "R4");
        write_map(2'd0, 16'h03FF);
        drive_data(16'h8ABC, "R5");
        write_map(2'd0, 16'h0010);
        drive_data(16'h9000, "R5 R8");
        write_map(2'd0, 16'h0018);
        drive_data(16'h8001, "R8");

        write_map(2'd1, 16'h0001);
        drive_fetch(16'h1234, "R7");
        drive_fetch(16'h9000, "R6");
        write_map(2'd2, 16'h0005);
        drive_fetch(16'hC000, "R7 R8");
        drive_fetch(16'h0FFF, "R6");

        // R10: select code 3 writes nothing
        write_map(2'd3, 16'h1000);
        drive_fetch(16'hC000, "R10");
        drive_data(16'h8001, "R10");

        // R9: same-cycle write does not affect that request, next one sees it
        data_with_write(16'h8004, 2'd0, 16'h1003, "R9");
        drive_data(16'h8004, "R9");

        // R9: back-to-back requests on both ports
        fork
            begin
                drive_data(16'h1234, "R9");
                drive_data(16'hFF08, "R9");
                drive_data(16'hA000, "R9");
            end
            begin
                drive_fetch(16'h0100, "R9");
                drive_fetch(16'hFFFF, "R9");
            end
        join

        repeat (4) @(negedge clk);
        n_checks++;
        if (dq.size() != 0 || fq.size() != 0) begin
            n_fail++;
            $display("FAIL R9 drain: actual pending=%0d expected 0", dq.size() + fq.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule